// File: doc/BRIEF.md
# Power-Management Event Status and Interrupt Unit

This unit gathers five power-management event sources and keeps a latched status flag for each: a sleep button, a real-time-clock alarm, a power button, a general wake input, and a PM timer overflow. Each source also has an enable bit. From the status and enable bits the unit derives three things. The first is a global wake-status flag. The second is a level-sensitive system control interrupt. The third is a one-cycle wakeup pulse to the power-state sequencer.

Software reaches the unit through a plain synchronous register port. It reads the status word, writes ones to clear flags, and reads or writes the enable word. The timer and the general wake input are produced elsewhere. Here they are treated as synchronous event lines.

Not every source behaves the same way. The two buttons and the alarm latch their flag even when they are disabled. The general wake input latches only when it is enabled. The timer overflow can raise the interrupt but never counts as a wakeup.

Top module: `pm_wake_sci`

## Requirements
- R1: A rising edge on the sleep button, alarm or power button input sets that source's status bit, whatever its enable. Status word layout at address 0: bit0 sleep button, bit1 alarm, bit2 power button, bit3 general wake, bit4 timer overflow, bit5 global wake flag.
- R2: A rising edge on the sleep button, alarm or power button input with its enable set also does two things. It sets the global wake flag (bit5), and it drives `wake_pulse_o` high for exactly the one cycle after the edge is registered.
- R3: A rising edge on the general wake input sets its status bit, the global wake flag and the wake pulse only while its enable is set. While it is disabled, the edge changes nothing.
- R4: A rising edge on the timer overflow input sets its status bit whatever its enable. It never sets the global wake flag and never raises the wake pulse.
- R5: `sci_o` is high exactly while at least one of status bits 0..4 is set together with the matching enable bit. Disabling a source drops its contribution at once, and the status bit is kept.
- R6: Writing to address 0 clears each status bit (0..5) whose data bit is one. Bits written as zero keep their value.
- R7: The enable word at address 1 is a read/write register: bits 0..4 use the same source order as the status word, and the upper bits read as zero. Any other address reads as zero.
- R8: When a source edge and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: A source input held high sets its status bit once. A further set needs the input to go low and rise again.
- R10: Reset clears every status bit, every enable bit and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_sleep_btn_i | input | 1 | Sleep button event line |
| ev_rtc_alarm_i | input | 1 | Real-time-clock alarm event line |
| ev_power_btn_i | input | 1 | Power button event line |
| ev_gen_wake_i | input | 1 | General wake event line |
| ev_tmr_ovf_i | input | 1 | PM timer overflow event line |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address (0 status, 1 enable) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address (combinational) |
| sci_o | output | 1 | System control interrupt, level |
| wake_pulse_o | output | 1 | One-cycle wakeup request to the power-state sequencer |

## Verification
The bench targets three corner cases:
- A power-button edge that lands on the same cycle as a clear of that bit. A design that gave priority to the clear would lose the event.
- A timer overflow with every enable set. A design that counted the timer as a wake source would raise the wake pulse or the global flag.
- An input held high across several cycles. A level-sensitive design would fire the wake pulse again.

The bench also checks two more cases:
- Disabling the timer source while its flag is set must drop the interrupt but keep the flag.
- A disabled general wake edge must leave no trace at all.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int NSRC = 5;
  localparam int SRC_SLEEP = 0;
  localparam int SRC_ALARM = 1;
  localparam int SRC_POWER = 2;
  localparam int SRC_GEN   = 3;
  localparam int SRC_TMR   = 4;
  localparam int GWAKE_BIT = NSRC;

  typedef logic [NSRC-1:0] src_vec_t;

  // sources allowed to request a wakeup
  localparam src_vec_t WAKE_CAPABLE = 5'b01111;
  // sources that latch status even when disabled
  localparam src_vec_t LATCH_ALWAYS = 5'b10111;
endpackage

// File: rtl/pm_edge_detect.sv
module pm_edge_detect #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pm_status_bank.sv
module pm_status_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic [W-1:0] st_en;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      st_en[g] = set_i[g] | clr_i[g];
      // set has priority over clear
      st_d[g]  = set_i[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q[g] <= 1'b0;
      else if (st_en[g]) st_q[g] <= st_d[g];
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/pm_sci_combine.sv
module pm_sci_combine
  import pm_wake_pkg::*;
(
  input  src_vec_t st_i,
  input  src_vec_t en_i,
  input  src_vec_t rise_i,
  output logic     sci_o,
  output logic     wake_hit_o,
  output src_vec_t set_o
);
  always_comb begin
    sci_o      = |(st_i & en_i);
    wake_hit_o = |(rise_i & en_i & WAKE_CAPABLE);
    set_o      = rise_i & (LATCH_ALWAYS | en_i);
  end
endmodule

// File: rtl/pm_wake_sci.sv
module pm_wake_sci
  import pm_wake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sleep_btn_i,
  input  logic              ev_rtc_alarm_i,
  input  logic              ev_power_btn_i,
  input  logic              ev_gen_wake_i,
  input  logic              ev_tmr_ovf_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sci_o,
  output logic              wake_pulse_o
);
  localparam int SW = NSRC + 1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);

  // reset synchronizer: async assert, sync release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  src_vec_t ev_vec;
  assign ev_vec = {ev_tmr_ovf_i, ev_gen_wake_i, ev_power_btn_i,
                   ev_rtc_alarm_i, ev_sleep_btn_i};

  src_vec_t rise;
  pm_edge_detect #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl_i(ev_vec), .rise_o(rise)
  );

  // enable register
  src_vec_t en_q;
  src_vec_t en_d;
  logic     en_we;
  always_comb begin
    en_we = bus_we_i && (bus_addr_i == ADDR_EN);
    en_d  = bus_wdata_i[NSRC-1:0];
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= '0;
    else if (en_we)  en_q <= en_d;
  end

  src_vec_t st_src;
  src_vec_t src_set;
  logic     wake_hit;
  logic     sci_int;
  pm_sci_combine u_comb (
    .st_i(st_src), .en_i(en_q), .rise_i(rise),
    .sci_o(sci_int), .wake_hit_o(wake_hit), .set_o(src_set)
  );

  // status bank: source bits plus global wake flag
  logic [SW-1:0] stat_set;
  logic [SW-1:0] clr_vec;
  logic [SW-1:0] stat_q;
  always_comb begin
    stat_set = {wake_hit, src_set};
    clr_vec  = (bus_we_i && (bus_addr_i == ADDR_STAT)) ? bus_wdata_i[SW-1:0] : '0;
  end
  pm_status_bank #(.W(SW)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(stat_set), .clr_i(clr_vec), .st_o(stat_q)
  );
  assign st_src = stat_q[NSRC-1:0];

  logic gwake_q;
  assign gwake_q = stat_q[GWAKE_BIT];

  // wake pulse register
  logic wake_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wake_q <= 1'b0;
    else             wake_q <= wake_hit;
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_STAT)    bus_rdata_o[SW-1:0]   = stat_q;
    else if (bus_addr_i == ADDR_EN) bus_rdata_o[NSRC-1:0] = en_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:SW];

  assign sci_o        = sci_int;
  assign wake_pulse_o = wake_q;
endmodule

// File: rtl/pm_wake_sci_chk.sv
module pm_wake_sci_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ev_i,
  input logic [4:0] en_i,
  input logic [4:0] st_i,
  input logic       gwake_i,
  input logic [5:0] clr_i,
  input logic       sci_i,
  input logic       wake_i
);
  AST_SLEEP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_i[0]) |=> st_i[0]); // R1
  AST_POWER_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_i[2]) |=> st_i[2]); // R8
  AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |-> gwake_i); // R2
  AST_GEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i[3] && !st_i[3]) |=> !st_i[3]); // R3
  AST_TMR_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_i[4]) |=> st_i[4]); // R4
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |-> $past(|en_i[3:0])); // R4
  AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sci_i |-> (|en_i)); // R5
  AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((({gwake_i, st_i}) & ($past({gwake_i, st_i}) & ~$past(clr_i)))
              == ($past({gwake_i, st_i}) & ~$past(clr_i)))); // R6
endmodule

bind pm_wake_sci pm_wake_sci_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ev_i(ev_vec), .en_i(en_q),
  .st_i(st_src), .gwake_i(gwake_q), .clr_i(clr_vec),
  .sci_i(sci_o), .wake_i(wake_pulse_o)
);

// File: tb/sim_pm_wake_sci.sv
module sim_pm_wake_sci;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ev = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sci, wake;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  pm_wake_sci u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_sleep_btn_i(ev[0]), .ev_rtc_alarm_i(ev[1]), .ev_power_btn_i(ev[2]),
    .ev_gen_wake_i(ev[3]), .ev_tmr_ovf_i(ev[4]),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sci_o(sci), .wake_pulse_o(wake)
  );

  // row: ev[5] we[1] addr[2] wdata[8] sci[1] wake[1] stat[8] tag[8]
  typedef logic [33:0] row_t;
  localparam int NROW = 16;
  localparam row_t VEC [NROW] = '{
    {5'b00001, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h01, 8'd1},  // R1 sleep, disabled
    {5'b00000, 1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 8'h00, 8'd6},  // R6 clear
    {5'b01000, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'd3},  // R3 gen disabled
    {5'b00000, 1'b1, 2'd1, 8'h1F, 1'b0, 1'b0, 8'h00, 8'd7},  // R7 enable all
    {5'b00010, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 8'h22, 8'd2},  // R2 alarm wakes
    {5'b00010, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h22, 8'd9},  // R9 held level
    {5'b00000, 1'b1, 2'd0, 8'h22, 1'b0, 1'b0, 8'h00, 8'd6},  // R6 clear
    {5'b10000, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h10, 8'd4},  // R4 timer no wake
    {5'b00000, 1'b1, 2'd1, 8'h0F, 1'b0, 1'b0, 8'h10, 8'd5},  // R5 timer disabled
    {5'b00000, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 8'h10, 8'd6},  // R6 write zero
    {5'b00000, 1'b1, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 8'd6},  // R6 clear timer
    {5'b01000, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 8'h28, 8'd3},  // R3 gen enabled
    {5'b00100, 1'b1, 2'd0, 8'h04, 1'b1, 1'b1, 8'h2C, 8'd8},  // R8 set beats clear
    {5'b00000, 1'b1, 2'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 8'd6},  // R6 clear all
    {5'b00000, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'd7},  // R7 disable all
    {5'b00100, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h04, 8'd1}   // R1 power, disabled
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [1:0] a, output logic [7:0] d);
    we = 1'b0; addr = a; #2; d = rdata;
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    read_at(2'd0, d); chk("R10 status", d, 8'h00);
    read_at(2'd1, d); chk("R10 enable", d, 8'h00);
    chk("R10 sci", {7'd0, sci}, 8'h00);
    chk("R10 wake", {7'd0, wake}, 8'h00);

    for (int i = 0; i < NROW; i++) begin
      row_t r = VEC[i];
      @(negedge clk);
      ev = r[33:29]; we = r[28]; addr = r[27:26]; wdata = r[25:18];
      @(posedge clk); #5;
      read_at(2'd0, d);
      chk($sformatf("R%0d row%0d status", r[7:0], i), d, r[15:8]);
      chk($sformatf("R%0d row%0d sci", r[7:0], i), {7'd0, sci}, {7'd0, r[17]});
      chk($sformatf("R%0d row%0d wake", r[7:0], i), {7'd0, wake}, {7'd0, r[16]});
    end

    // R7 enable read-back and unused address
    @(negedge clk); ev = '0; we = 1'b1; addr = 2'd1; wdata = 8'hF5;
    @(posedge clk); #5;
    read_at(2'd1, d); chk("R7 enable readback", d, 8'h15);
    read_at(2'd2, d); chk("R7 unused addr", d, 8'h00);
    chk("R5 sci with power set+enabled", {7'd0, sci}, 8'h01);

    // R9: held power button wakes once only
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'hFF;
    @(negedge clk); we = 1'b0; ev = 5'b00100;
    @(posedge clk); #5; chk("R9 first wake", {7'd0, wake}, 8'h01);
    @(posedge clk); #5; chk("R9 no rewake", {7'd0, wake}, 8'h00);

    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0; ev = '0;
    #3;
    read_at(2'd0, d); chk("R10 status after reset", d, 8'h00);
    read_at(2'd1, d); chk("R10 enable after reset", d, 8'h00);
    chk("R10 sci after reset", {7'd0, sci}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule